// File: doc/BRIEF.md
# Load-Use Dependency Classifier

This block sits beside the issue logic of a five-stage integer pipeline whose loads deliver their data one instruction late. When a load is in flight, the pipeline presents the index of the load's destination register together with the 32-bit word of the instruction that follows the load. The block works out how that following instruction relates to the register. The instruction may ignore it, only read it, only write it, or both read and write it.

The relation comes out as a two-bit dependency code. Alongside it the block gives a two-bit action telling the commit logic what to do with the loaded value. The value may be committed as usual, discarded, or held back so that the following instruction still sees the old contents and the new value lands after it. Both outputs are registered and appear one cycle after a valid request.

Top module: `load_use_classifier`

## Requirements
- R1: Fields are taken as opcode = word[31:26], rs = word[25:21], rt = word[20:16], rd = word[15:11], function = word[5:0]. A word of all zeros gives dependency code 0 for any register index, including index 0.
- R2: Dependency codes are 0 = unrelated, 1 = read and written, 2 = read only, 3 = written only. The action output is 1 (discard) for code 1, 2 (defer) for code 2, and 0 (commit) for codes 0 and 3.
- R3: Opcode 0 with function 0x00, 0x02 or 0x03 reads rt and writes rd, and rs is not consulted. Function 0x04, 0x06, 0x07, 0x20 to 0x27, 0x2A and 0x2B reads rs and rt and writes rd.
- R4: Function 0x08 reads rs only. Function 0x09 reads rs and writes rd. Opcode 0x03 writes only when the register index is 31, and otherwise gives 0.
- R5: Functions 0x10 and 0x12 write rd only. Functions 0x11 and 0x13 read rs only. Functions 0x18 to 0x1B read rs and rt, and rd is not consulted.
- R6: Opcodes 0x08 to 0x0E read rs and write rt. Opcode 0x0F writes rt only, and rs is not consulted.
- R7: Opcodes 0x04 and 0x05 read rs and rt. Opcodes 0x06 and 0x07 read rs only. Opcode 0x01 with rt = 0x00, 0x01, 0x10 or 0x11 reads rs only, and other rt values there give 0.
- R8: Opcodes 0x20, 0x21, 0x23, 0x24 and 0x25 read rs and write rt. Opcodes 0x22 and 0x26 give code 3 whenever rt matches, even when rs also matches, and give code 2 when only rs matches.
- R9: Opcodes 0x28, 0x29, 0x2A, 0x2B and 0x2E read rs and rt and never write. Opcodes 0x32 and 0x3A read rs only.
- R10: Opcodes 0x10 and 0x12 are coprocessor moves selected by rs. rs = 0x00 or 0x02 writes rt, and rs = 0x04 or 0x06 reads rt. For opcode 0x12 this holds only when the function field is zero, and otherwise gives 0.
- R11: Every encoding not listed above gives code 0, for example opcode 0x3F and opcode 0 with function 0x01 or 0x0C.
- R12: The outputs update one cycle after a cycle with the valid input high. After a cycle with it low, out_valid is 0 and code and action are 0, whatever the other inputs carry.
- R13: While reset is high, out_valid, code and action are all 0 after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request qualifier for load_idx and next_word |
| load_idx | input | 5 | Destination register index of the pending load |
| next_word | input | 32 | Instruction word following the load |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| use_code | output | 2 | Dependency code (R2) |
| action | output | 2 | Load-value action (R2) |

## Verification
The assertions take for granted that load_idx and next_word are stable and meaningful only in cycles where in_valid is high. They also assume in_valid is low while reset is asserted. The bench changes its inputs only on falling edges. It raises in_valid only together with a fully formed word, and during idle cycles it drives junk words and indices with in_valid low, so the ignored-input property is exercised without breaking these assumptions.

// File: rtl/luc_pkg.sv
package luc_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 5;
    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int OP_LSB = WORD_W - OP_W;
    localparam int RS_LSB = OP_LSB - IDX_W;
    localparam int RT_LSB = RS_LSB - IDX_W;
    localparam int RD_LSB = RT_LSB - IDX_W;
    localparam logic [IDX_W-1:0] LINK_IDX = '1;

    typedef enum logic [1:0] {
        USE_NONE  = 2'd0,
        USE_BOTH  = 2'd1,
        USE_READ  = 2'd2,
        USE_WRITE = 2'd3
    } use_e;

    typedef enum logic [1:0] {
        ACT_COMMIT  = 2'd0,
        ACT_DISCARD = 2'd1,
        ACT_DEFER   = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        FLD_RS,
        FLD_RT,
        FLD_RD,
        FLD_LINK
    } fld_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [IDX_W-1:0] rs;
        logic [IDX_W-1:0] rt;
        logic [IDX_W-1:0] rd;
        logic [FN_W-1:0]  fn;
    } fields_t;

    typedef struct packed {
        logic src0_en;
        fld_e src0_fld;
        logic src1_en;
        fld_e src1_fld;
        logic dst_en;
        fld_e dst_fld;
        logic dst_wins;
    } role_t;

    localparam int NSRC = 2;

    function automatic fields_t split_word(input logic [WORD_W-1:0] w);
        fields_t f;
        f.op = w[OP_LSB +: OP_W];
        f.rs = w[RS_LSB +: IDX_W];
        f.rt = w[RT_LSB +: IDX_W];
        f.rd = w[RD_LSB +: IDX_W];
        f.fn = w[FN_W-1:0];
        return f;
    endfunction

    function automatic logic [IDX_W-1:0] field_index(input fields_t f, input fld_e s);
        case (s)
            FLD_RS:  return f.rs;
            FLD_RT:  return f.rt;
            FLD_RD:  return f.rd;
            default: return LINK_IDX;
        endcase
    endfunction

    function automatic act_e action_of(input use_e c);
        case (c)
            USE_BOTH: return ACT_DISCARD;
            USE_READ: return ACT_DEFER;
            default:  return ACT_COMMIT;
        endcase
    endfunction
endpackage

// File: rtl/luc_opclass_decode.sv
module luc_opclass_decode
    import luc_pkg::*;
(
    input  fields_t f,
    input  logic    word_zero,
    output role_t   role
);
    function automatic role_t mk(input logic s0, input fld_e f0, input logic s1, input fld_e f1,
                                 input logic d, input fld_e fd, input logic w);
        role_t r;
        r.src0_en = s0; r.src0_fld = f0;
        r.src1_en = s1; r.src1_fld = f1;
        r.dst_en  = d;  r.dst_fld  = fd;
        r.dst_wins = w;
        return r;
    endfunction

    role_t special_role, regimm_role, main_role, cop_role;

    always_comb begin
        special_role = mk(1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0);
        case (f.fn)
            6'h00, 6'h02, 6'h03:
                special_role = mk(1'b1, FLD_RT, 1'b0, FLD_RS, 1'b1, FLD_RD, 1'b0);
            6'h04, 6'h06, 6'h07,
            6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
            6'h2A, 6'h2B:
                special_role = mk(1'b1, FLD_RS, 1'b1, FLD_RT, 1'b1, FLD_RD, 1'b0);
            6'h08, 6'h11, 6'h13:
                special_role = mk(1'b1, FLD_RS, 1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0);
            6'h09:
                special_role = mk(1'b1, FLD_RS, 1'b0, FLD_RS, 1'b1, FLD_RD, 1'b0);
            6'h10, 6'h12:
                special_role = mk(1'b0, FLD_RS, 1'b0, FLD_RS, 1'b1, FLD_RD, 1'b0);
            6'h18, 6'h19, 6'h1A, 6'h1B:
                special_role = mk(1'b1, FLD_RS, 1'b1, FLD_RT, 1'b0, FLD_RS, 1'b0);
            default: ;
        endcase
    end

    always_comb begin
        regimm_role = mk(1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0);
        case (f.rt)
            5'h00, 5'h01, 5'h10, 5'h11:
                regimm_role = mk(1'b1, FLD_RS, 1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0);
            default: ;
        endcase
    end

    // Coprocessor move direction comes from rs; the second coprocessor
    // additionally needs a zero function field.
    logic cop_enable;
    always_comb begin
        cop_enable = (f.op == 6'h10) || (f.fn == '0);
        cop_role   = mk(1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0);
        if (cop_enable) begin
            case (f.rs)
                5'h00, 5'h02: cop_role = mk(1'b0, FLD_RS, 1'b0, FLD_RS, 1'b1, FLD_RT, 1'b0);
                5'h04, 5'h06: cop_role = mk(1'b1, FLD_RT, 1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0);
                default: ;
            endcase
        end
    end

    always_comb begin
        main_role = mk(1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0);
        case (f.op)
            6'h00: main_role = special_role;
            6'h01: main_role = regimm_role;
            6'h03: main_role = mk(1'b0, FLD_RS, 1'b0, FLD_RS, 1'b1, FLD_LINK, 1'b0);
            6'h04, 6'h05:
                main_role = mk(1'b1, FLD_RS, 1'b1, FLD_RT, 1'b0, FLD_RS, 1'b0);
            6'h06, 6'h07, 6'h32, 6'h3A:
                main_role = mk(1'b1, FLD_RS, 1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0);
            6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E,
            6'h20, 6'h21, 6'h23, 6'h24, 6'h25:
                main_role = mk(1'b1, FLD_RS, 1'b0, FLD_RS, 1'b1, FLD_RT, 1'b0);
            6'h0F:
                main_role = mk(1'b0, FLD_RS, 1'b0, FLD_RS, 1'b1, FLD_RT, 1'b0);
            6'h10, 6'h12:
                main_role = cop_role;
            6'h22, 6'h26:
                main_role = mk(1'b1, FLD_RS, 1'b0, FLD_RS, 1'b1, FLD_RT, 1'b1);
            6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2E:
                main_role = mk(1'b1, FLD_RS, 1'b1, FLD_RT, 1'b0, FLD_RS, 1'b0);
            default: ;
        endcase
        role = word_zero ? mk(1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0, FLD_RS, 1'b0) : main_role;
    end
endmodule

// File: rtl/luc_dep_match.sv
module luc_dep_match
    import luc_pkg::*;
(
    input  fields_t          f,
    input  role_t            role,
    input  logic [IDX_W-1:0] load_idx,
    output use_e             code
);
    logic [NSRC-1:0] src_en;
    fld_e            src_fld [NSRC];
    logic [NSRC-1:0] src_hit;

    always_comb begin
        src_en[0]  = role.src0_en;
        src_en[1]  = role.src1_en;
        src_fld[0] = role.src0_fld;
        src_fld[1] = role.src1_fld;
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign src_hit[k] = src_en[k] && (field_index(f, src_fld[k]) == load_idx);
    end

    logic any_read, dst_hit;
    assign any_read = |src_hit;
    assign dst_hit  = role.dst_en && (field_index(f, role.dst_fld) == load_idx);

    always_comb begin
        if (dst_hit && (role.dst_wins || !any_read)) code = USE_WRITE;
        else if (dst_hit)                           code = USE_BOTH;
        else if (any_read)                          code = USE_READ;
        else                                        code = USE_NONE;
    end
endmodule

// File: rtl/luc_out_stage.sv
module luc_out_stage
    import luc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  use_e code_in,
    output logic out_valid,
    output use_e code_q,
    output act_e act_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            code_q    <= USE_NONE;
            act_q     <= ACT_COMMIT;
        end else begin
            out_valid <= in_valid;
            code_q    <= in_valid ? code_in : USE_NONE;
            act_q     <= in_valid ? action_of(code_in) : ACT_COMMIT;
        end
    end

    // R2: the action travels with its code
    a_r2_discard_pairs: assert property (@(posedge clk) disable iff (rst)
        (code_q == USE_BOTH) |-> (act_q == ACT_DISCARD));
    a_r2_defer_pairs: assert property (@(posedge clk) disable iff (rst)
        (code_q == USE_READ) |-> (act_q == ACT_DEFER));
    a_r2_commit_pairs: assert property (@(posedge clk) disable iff (rst)
        (code_q == USE_NONE || code_q == USE_WRITE) |-> (act_q == ACT_COMMIT));
endmodule

// File: rtl/load_use_classifier.sv
module load_use_classifier
    import luc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [WORD_W-1:0] next_word,
    output logic              out_valid,
    output logic [1:0]        use_code,
    output logic [1:0]        action
);
    fields_t fields;
    role_t   role;
    use_e    code_c, code_q;
    act_e    act_q;
    logic    word_zero;

    assign fields    = split_word(next_word);
    assign word_zero = (next_word == '0);

    luc_opclass_decode u_decode (
        .f         (fields),
        .word_zero (word_zero),
        .role      (role)
    );

    luc_dep_match u_match (
        .f        (fields),
        .role     (role),
        .load_idx (load_idx),
        .code     (code_c)
    );

    luc_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .code_in   (code_c),
        .out_valid (out_valid),
        .code_q    (code_q),
        .act_q     (act_q)
    );

    assign use_code = code_q;
    assign action   = act_q;

    a_r1_zero_word: assert property (@(posedge clk) disable iff (rst)
        (in_valid && next_word == '0) |=> (use_code == 2'd0));
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && use_code == 2'd0 && action == 2'd0));
    a_r6_upper_imm_no_read: assert property (@(posedge clk) disable iff (rst)
        (in_valid && next_word[31:26] == 6'h0F) |=> (use_code == 2'd0 || use_code == 2'd3));
    a_r9_store_no_write: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (next_word[31:26] == 6'h28 || next_word[31:26] == 6'h29 ||
                      next_word[31:26] == 6'h2A || next_word[31:26] == 6'h2B ||
                      next_word[31:26] == 6'h2E))
        |=> (use_code == 2'd0 || use_code == 2'd2));
    a_r4_link_other_reg: assert property (@(posedge clk) disable iff (rst)
        (in_valid && next_word[31:26] == 6'h03 && load_idx != 5'd31) |=> (use_code == 2'd0));
endmodule

// File: tb/load_use_classifier_bench.sv
module load_use_classifier_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  load_idx = '0;
    logic [31:0] next_word = '0;
    logic        out_valid;
    logic [1:0]  use_code, action;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    bit mon_on = 0;

    typedef struct {
        logic [1:0] code;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    load_use_classifier u_load_use_classifier (
        .clk(clk), .rst(rst), .in_valid(in_valid), .load_idx(load_idx),
        .next_word(next_word), .out_valid(out_valid), .use_code(use_code), .action(action)
    );

    function automatic logic [31:0] rw(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd3, fn};
    endfunction

    function automatic logic [31:0] iw(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [1:0] act_for(input logic [1:0] c);
        if (c == 2'd1) return 2'd1;
        if (c == 2'd2) return 2'd2;
        return 2'd0;
    endfunction

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic send(input logic [4:0] idx, input logic [31:0] w,
                        input logic [1:0] code, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        load_idx  = idx;
        next_word = w;
        e.code = code;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            load_idx  = 5'(i + 3);
            next_word = 32'hDEAD_0000 ^ 32'(i * 32'h0101_0123);
        end
    endtask

    // monitor: pop and compare as results emerge
    always @(negedge clk) begin
        if (mon_on && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R12 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(use_code == e.code, {e.tag, " code"}, use_code, e.code);
                    chk(action == act_for(e.code), {e.tag, " R2 action"}, action, act_for(e.code));
                end
            end else begin
                chk(use_code == 2'd0 && action == 2'd0, "R12 idle outputs zero",
                    {use_code, action}, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && use_code == 0 && action == 0, "R13 reset state",
            {out_valid, use_code, action}, 0);
        rst = 1'b0;
        mon_on = 1;

        // R1
        send(5'd5, 32'h0, 2'd0, "R1 zero word idx5");
        send(5'd0, 32'h0, 2'd0, "R1 zero word idx0");
        send(5'd0, 32'h0000_0040, 2'd1, "R1 nonzero shift on idx0");
        // R3
        send(5'd5, rw(5'd0, 5'd5, 5'd5, 6'h00), 2'd1, "R3 shift both");
        send(5'd5, rw(5'd0, 5'd5, 5'd3, 6'h00), 2'd2, "R3 shift read");
        send(5'd5, rw(5'd0, 5'd2, 5'd5, 6'h02), 2'd3, "R3 shift write");
        send(5'd5, rw(5'd5, 5'd1, 5'd2, 6'h03), 2'd0, "R3 shift rs ignored");
        send(5'd7, rw(5'd7, 5'd1, 5'd7, 6'h21), 2'd1, "R3 alu both");
        send(5'd7, rw(5'd1, 5'd7, 5'd2, 6'h22), 2'd2, "R3 alu read rt");
        send(5'd7, rw(5'd1, 5'd2, 5'd7, 6'h2B), 2'd3, "R3 alu write");
        send(5'd7, rw(5'd1, 5'd7, 5'd2, 6'h04), 2'd2, "R3 var shift read");
        idle(2);
        // R4
        send(5'd9, rw(5'd9, 5'd0, 5'd0, 6'h08), 2'd2, "R4 reg jump read");
        send(5'd9, rw(5'd9, 5'd0, 5'd9, 6'h09), 2'd1, "R4 link jump both");
        send(5'd9, rw(5'd1, 5'd0, 5'd9, 6'h09), 2'd3, "R4 link jump write");
        send(5'd31, iw(6'h03, 5'd31, 5'd31, 16'h1234), 2'd3, "R4 call idx31");
        send(5'd30, iw(6'h03, 5'd30, 5'd30, 16'hFFFF), 2'd0, "R4 call idx30");
        // R5
        send(5'd4, rw(5'd0, 5'd0, 5'd4, 6'h10), 2'd3, "R5 move from hi");
        send(5'd4, rw(5'd4, 5'd0, 5'd0, 6'h13), 2'd2, "R5 move to lo");
        send(5'd4, rw(5'd1, 5'd4, 5'd0, 6'h18), 2'd2, "R5 multiply read");
        send(5'd4, rw(5'd1, 5'd2, 5'd4, 6'h1B), 2'd0, "R5 divide rd ignored");
        // R6
        send(5'd6, iw(6'h08, 5'd6, 5'd6, 16'h0001), 2'd1, "R6 imm both");
        send(5'd6, iw(6'h0D, 5'd6, 5'd2, 16'h00FF), 2'd2, "R6 imm read");
        send(5'd6, iw(6'h0B, 5'd1, 5'd6, 16'h0010), 2'd3, "R6 imm write");
        send(5'd6, iw(6'h0F, 5'd0, 5'd6, 16'hABCD), 2'd3, "R6 upper imm write");
        send(5'd6, iw(6'h0F, 5'd6, 5'd1, 16'hABCD), 2'd0, "R6 upper imm rs ignored");
        idle(1);
        // R7
        send(5'd8, iw(6'h04, 5'd1, 5'd8, 16'h0004), 2'd2, "R7 eq branch rt");
        send(5'd8, iw(6'h07, 5'd1, 5'd8, 16'h0004), 2'd0, "R7 gtz rt ignored");
        send(5'd8, iw(6'h07, 5'd8, 5'd0, 16'h0004), 2'd2, "R7 gtz rs");
        send(5'd8, iw(6'h01, 5'd8, 5'h11, 16'h0004), 2'd2, "R7 regimm link");
        send(5'd8, iw(6'h01, 5'd8, 5'h03, 16'h0004), 2'd0, "R7 regimm unlisted");
        // R8
        send(5'd10, iw(6'h23, 5'd10, 5'd10, 16'h0000), 2'd1, "R8 word load both");
        send(5'd10, iw(6'h20, 5'd10, 5'd1, 16'h0000), 2'd2, "R8 byte load read");
        send(5'd10, iw(6'h25, 5'd2, 5'd10, 16'h0000), 2'd3, "R8 half load write");
        send(5'd10, iw(6'h22, 5'd10, 5'd10, 16'h0001), 2'd3, "R8 left load rt wins");
        send(5'd10, iw(6'h26, 5'd10, 5'd1, 16'h0002), 2'd2, "R8 right load rs");
        // R9
        send(5'd11, iw(6'h2B, 5'd1, 5'd11, 16'h0000), 2'd2, "R9 store rt");
        send(5'd11, iw(6'h28, 5'd11, 5'd11, 16'h0000), 2'd2, "R9 store both fields");
        send(5'd11, iw(6'h3A, 5'd1, 5'd11, 16'h0000), 2'd0, "R9 cop store rt ignored");
        send(5'd11, iw(6'h32, 5'd11, 5'd1, 16'h0000), 2'd2, "R9 cop load rs");
        idle(3);
        // R10
        send(5'd12, iw(6'h10, 5'h00, 5'd12, 16'h6000), 2'd3, "R10 cop0 move from");
        send(5'd12, iw(6'h10, 5'h04, 5'd12, 16'h6000), 2'd2, "R10 cop0 move to");
        send(5'd12, iw(6'h12, 5'h02, 5'd12, 16'h6000), 2'd3, "R10 cop2 control from");
        send(5'd12, iw(6'h12, 5'h00, 5'd12, 16'h6001), 2'd0, "R10 cop2 nonzero fn");
        send(5'd12, iw(6'h12, 5'h06, 5'd12, 16'h0800), 2'd2, "R10 cop2 control to");
        // R11
        send(5'd13, iw(6'h3F, 5'd13, 5'd13, 16'h0000), 2'd0, "R11 unlisted opcode");
        send(5'd13, rw(5'd13, 5'd13, 5'd13, 6'h01), 2'd0, "R11 unlisted function");
        send(5'd13, rw(5'd13, 5'd13, 5'd13, 6'h0C), 2'd0, "R11 trap function");
        idle(4);
        chk(sb.size() == 0, "R12 all results delivered", sb.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule